// File: doc/BRIEF.md
# I2C Slave Address Front End

This block is the serial front end of a small I/O-expander device. It samples the two bus lines with the system clock and recognises START and STOP conditions. After a START it collects the address byte. It answers with an acknowledge only when that byte selects this device, and it then moves data bytes between the bus and a plain parallel user interface. The device address has seven bits. The upper four are a fixed prefix set by a parameter, with a default of binary 0011. The lower three come from strap inputs, so up to eight copies of the device can share one bus.

In a write, each received byte appears on `wr_data` together with a one-cycle `wr_valid` pulse, and the block acknowledges it. In a read, the block takes a byte from `rd_data` at the start of each byte slot and pulses `rd_req` so that the user side can advance. It then shifts the byte out with the most significant bit first. SDA is driven open-drain: `sda_oe` high pulls the line low, and `sda_oe` low releases it. The system clock must run at least eight times faster than SCL. Clock stretching, 10-bit addressing and general call are not supported.

Top module: `pxp_i2c_slave`

## Requirements
- R1: Until the first START after reset, bus traffic has no effect: `sda_oe`, `wr_valid` and `selected` stay low.
- R2: A STOP (SDA rising while SCL is high) ends any transaction: `selected` and `sda_oe` go low, and the block stays idle until a START.
- R3: A change on SDA while SCL is high is treated as a START or STOP condition and never as a data bit. A STOP in the middle of a byte drops that byte, so no `wr_valid` pulse follows.
- R4: The address byte is received MSB first. It matches when bits 7..4 equal the prefix (binary 0011) and bits 3..1 equal `dev_sel[2:0]`.
- R5: When the address does not match, `sda_oe` stays low until the next START.
- R6: When the address matches, SDA is held low (`sda_oe`=1) during the ninth SCL high phase, and `selected` rises.
- R7: After a match, `rw_dir` shows bit 0 of the address byte: 1 means a read (the slave transmits) and 0 means a write (the slave receives).
- R8: A repeated START in the middle of a byte abandons that byte and restarts address reception. No `wr_valid` pulse comes from the partial byte.
- R9: In a write, each complete data byte appears on `wr_data` with a `wr_valid` pulse exactly one cycle wide, and the slave acknowledges the byte.
- R10: In a read, the byte taken from `rd_data` at the start of the slot is sent MSB first. `sda_oe` changes only while SCL is low.
- R11: When the master sends a NACK after a read byte, the slave keeps `sda_oe` low until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_sel | input | 3 | Strap inputs forming address bits 3..1 |
| sda_oe | output | 1 | Pulls SDA low when high; releases SDA when low |
| selected | output | 1 | High from an address match until STOP or START |
| rw_dir | output | 1 | Transfer direction: 1 = read, 0 = write |
| wr_data | output | 8 | Last byte received in a write |
| wr_valid | output | 1 | One-cycle pulse marking a new `wr_data` byte |
| rd_data | input | 8 | Byte to transmit in a read, sampled at `rd_req` |
| rd_req | output | 1 | One-cycle pulse when `rd_data` is loaded |

## Verification
The assertions check on every cycle the properties that hold locally in time:
- `sda_oe` only rises while the synchronized SCL is low.
- A STOP or START clears `selected` and `sda_oe` on the next cycle.
- `sda_oe` is never asserted unless the device is selected.
- `wr_valid` is a single-cycle pulse that appears only in a write.
- `rd_req` appears only in a read.

Only the bench scenarios can show the behaviour that depends on whole transactions: whether the address comparison against the strap inputs is correct, the byte values moved in each direction, that a NACK silences the slave, and that a partial byte is dropped when a repeated START or a mid-byte STOP arrives.

// File: rtl/pxp_i2c_pkg.sv
package pxp_i2c_pkg;

    localparam int BYTE_W    = 8;
    localparam int BIT_CNT_W = $clog2(BYTE_W);

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_END,
        PH_ACK,
        PH_WR,
        PH_WR_END,
        PH_RD,
        PH_RD_MACK,
        PH_RD_MEND,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        phase_e                 phase;
        logic [BYTE_W-1:0]      shreg;
        logic [BIT_CNT_W-1:0]   bcnt;
        logic                   rw;
        logic                   sel;
        logic                   oe;
        logic                   wvld;
        logic                   rreq;
        logic                   mnak;
    } core_t;

endpackage

// File: rtl/pxp_sync.sv
module pxp_sync #(
    parameter int               WIDTH   = 2,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d[0] = d_i;
        for (int s = 1; s < STAGES; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= {STAGES{RST_VAL}};
        else        pipe_q <= pipe_d;
    end

    assign q_o = pipe_q[STAGES-1];

endmodule

// File: rtl/pxp_i2c_cond.sv
module pxp_i2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    // Conditions need SCL high on both samples; SDA moving in between marks them.
    assign scl_rise  = !prev_q.scl &&  scl_s;
    assign scl_fall  =  prev_q.scl && !scl_s;
    assign start_det =  prev_q.scl &&  scl_s &&  prev_q.sda && !sda_s;
    assign stop_det  =  prev_q.scl &&  scl_s && !prev_q.sda &&  sda_s;

endmodule

// File: rtl/pxp_i2c_slave.sv
module pxp_i2c_slave
    import pxp_i2c_pkg::*;
#(
    parameter int                            ADDR_W      = 7,
    parameter int                            STRAP_W     = 3,
    parameter logic [ADDR_W-STRAP_W-1:0]     DEV_PREFIX  = 4'b0011,
    parameter int                            SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    input  logic [STRAP_W-1:0] dev_sel,
    output logic               sda_oe,
    output logic               selected,
    output logic               rw_dir,
    output logic [BYTE_W-1:0]  wr_data,
    output logic               wr_valid,
    input  logic [BYTE_W-1:0]  rd_data,
    output logic               rd_req
);

    localparam logic [BIT_CNT_W-1:0] LAST_BIT = BIT_CNT_W'(BYTE_W - 1);

    logic [1:0] line_s;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_det, stop_det;
    logic       addr_hit;

    pxp_sync #(
        .WIDTH   (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b11)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   (line_s)
    );

    assign scl_s = line_s[1];
    assign sda_s = line_s[0];

    pxp_i2c_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    core_t cq, cd;

    assign addr_hit = (cq.shreg[BYTE_W-1 -: ADDR_W] == {DEV_PREFIX, dev_sel});

    always_comb begin
        cd      = cq;
        cd.wvld = 1'b0;
        cd.rreq = 1'b0;

        if (stop_det) begin
            cd.phase = PH_IDLE;
            cd.oe    = 1'b0;
            cd.sel   = 1'b0;
        end else if (start_det) begin
            // Fresh or repeated START: any partial byte is dropped here.
            cd.phase = PH_ADDR;
            cd.bcnt  = '0;
            cd.oe    = 1'b0;
            cd.sel   = 1'b0;
        end else begin
            unique case (cq.phase)
                PH_IDLE, PH_HOLD: ;
                PH_ADDR: begin
                    if (scl_rise) begin
                        cd.shreg = {cq.shreg[BYTE_W-2:0], sda_s};
                        cd.bcnt  = cq.bcnt + 1'b1;
                        if (cq.bcnt == LAST_BIT) cd.phase = PH_ADDR_END;
                    end
                end
                PH_ADDR_END: begin
                    if (scl_fall) begin
                        if (addr_hit) begin
                            cd.phase = PH_ACK;
                            cd.sel   = 1'b1;
                            cd.rw    = cq.shreg[0];
                            cd.oe    = 1'b1;
                        end else begin
                            cd.phase = PH_IDLE;
                        end
                    end
                end
                PH_ACK: begin
                    if (scl_fall) begin
                        cd.bcnt = '0;
                        if (cq.rw) begin
                            cd.phase = PH_RD;
                            cd.shreg = rd_data;
                            cd.oe    = !rd_data[BYTE_W-1];
                            cd.rreq  = 1'b1;
                        end else begin
                            cd.phase = PH_WR;
                            cd.oe    = 1'b0;
                        end
                    end
                end
                PH_WR: begin
                    if (scl_rise) begin
                        cd.shreg = {cq.shreg[BYTE_W-2:0], sda_s};
                        cd.bcnt  = cq.bcnt + 1'b1;
                        if (cq.bcnt == LAST_BIT) cd.phase = PH_WR_END;
                    end
                end
                PH_WR_END: begin
                    if (scl_fall) begin
                        cd.phase = PH_ACK;
                        cd.oe    = 1'b1;
                        cd.wvld  = 1'b1;
                    end
                end
                PH_RD: begin
                    if (scl_fall) begin
                        if (cq.bcnt == LAST_BIT) begin
                            cd.phase = PH_RD_MACK;
                            cd.oe    = 1'b0;
                        end else begin
                            cd.bcnt  = cq.bcnt + 1'b1;
                            cd.shreg = {cq.shreg[BYTE_W-2:0], 1'b0};
                            cd.oe    = !cq.shreg[BYTE_W-2];
                        end
                    end
                end
                PH_RD_MACK: begin
                    if (scl_rise) begin
                        cd.mnak  = sda_s;
                        cd.phase = PH_RD_MEND;
                    end
                end
                PH_RD_MEND: begin
                    if (scl_fall) begin
                        if (cq.mnak) begin
                            cd.phase = PH_HOLD;
                        end else begin
                            cd.phase = PH_RD;
                            cd.bcnt  = '0;
                            cd.shreg = rd_data;
                            cd.oe    = !rd_data[BYTE_W-1];
                            cd.rreq  = 1'b1;
                        end
                    end
                end
                default: cd.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cq <= '{phase: PH_IDLE, default: '0};
        end else begin
            cq <= cd;
        end
    end

    assign sda_oe   = cq.oe;
    assign selected = cq.sel;
    assign rw_dir   = cq.rw;
    assign wr_data  = cq.shreg;
    assign wr_valid = cq.wvld;
    assign rd_req   = cq.rreq;

endmodule

// File: rtl/pxp_i2c_slave_chk.sv
module pxp_i2c_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_s,
    input logic start_det,
    input logic stop_det,
    input logic sda_oe,
    input logic selected,
    input logic rw_dir,
    input logic wr_valid,
    input logic rd_req
);

    a_r10_oe_rises_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(scl_s));

    a_r2_stop_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!selected && !sda_oe));

    a_r8_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (!selected && !sda_oe));

    a_r5_drive_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe |-> selected);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    a_r9_pulse_in_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (selected && !rw_dir));

    a_r10_load_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (selected && rw_dir));

endmodule

bind pxp_i2c_slave pxp_i2c_slave_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .selected  (selected),
    .rw_dir    (rw_dir),
    .wr_valid  (wr_valid),
    .rd_req    (rd_req)
);

// File: tb/pxp_i2c_slave_tb_top.sv
module pxp_i2c_slave_tb_top;

    localparam int Q       = 10;
    localparam int WD_MAX  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic [2:0] dev_sel = 3'd0;
    logic [7:0] rd_data = 8'h00;
    logic       sda_oe, selected, rw_dir, wr_valid, rd_req;
    logic [7:0] wr_data;
    logic       sda_line;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    pxp_i2c_slave dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .dev_sel  (dev_sel),
        .sda_oe   (sda_oe),
        .selected (selected),
        .rw_dir   (rw_dir),
        .wr_data  (wr_data),
        .wr_valid (wr_valid),
        .rd_data  (rd_data),
        .rd_req   (rd_req)
    );

    // Monitors, sampled away from the active edge
    int         oe_cycles = 0;
    int         wr_n = 0;
    int         wide_pulses = 0;
    int         hi_changes = 0;
    logic [7:0] wr_log [256];
    logic       wv_prev = 1'b0, oe_prev = 1'b0, scl_prev = 1'b1;
    int         cyc = 0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (sda_oe) oe_cycles <= oe_cycles + 1;
        if (wr_valid) begin
            wr_log[wr_n[7:0]] <= wr_data;
            wr_n <= wr_n + 1;
        end
        if (wr_valid && wv_prev) wide_pulses <= wide_pulses + 1;
        if (scl_m && scl_prev && (sda_oe != oe_prev)) hi_changes <= hi_changes + 1;
        wv_prev  <= wr_valid;
        oe_prev  <= sda_oe;
        scl_prev <= scl_m;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit exp_ack(input logic [7:0] a, input logic [2:0] strap);
        return (a[7:4] == 4'b0011) && (a[3:1] == strap);
    endfunction

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_cycle(input logic b, output logic s);
        sda_m = b;  wq(Q);
        scl_m = 1;  wq(Q);
        s = sda_line; wq(Q);
        scl_m = 0;  wq(Q);
    endtask

    task automatic bus_start();
        sda_m = 1; wq(Q);
        scl_m = 1; wq(Q);
        sda_m = 0; wq(Q);
        scl_m = 0; wq(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(Q);
        scl_m = 1; wq(Q);
        sda_m = 1; wq(2 * Q);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit acked);
        logic s;
        for (int i = 7; i >= 0; i--) bit_cycle(b[i], s);
        bit_cycle(1'b1, s);
        acked = (s == 1'b0);
    endtask

    task automatic rbyte(output logic [7:0] b, input bit mack, input logic [7:0] nxt);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_cycle(1'b1, s);
            b[i] = s;
        end
        rd_data = nxt;
        bit_cycle(!mack, s);
        sda_m = 1;
    endtask

    initial begin
        bit         ack;
        logic [7:0] got, addr;
        logic       s;
        int         base, nb, oe0;
        logic [7:0] q [4];

        wq(5);
        chk(sda_oe == 0 && wr_valid == 0 && selected == 0, "R1 reset", {selected, wr_valid, sda_oe}, 0);
        rst_n = 1; wq(5);

        // R1: a matching address clocked without START is ignored
        dev_sel = 3'd3;
        scl_m = 0; wq(Q);
        oe0 = oe_cycles;
        wbyte(8'h36, ack);
        chk(!ack && oe_cycles == oe0 && !selected, "R1 no-start", ack, 0);
        wq(Q); scl_m = 1; sda_m = 1; wq(Q); bus_stop();

        // Directed write
        bus_start();
        wbyte({4'b0011, 3'd3, 1'b0}, ack);
        chk(ack, "R6 addr ack", ack, 1);
        chk(selected && rw_dir == 0, "R7 write dir", {selected, rw_dir}, 2);
        base = wr_n;
        q = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
        for (int k = 0; k < 4; k++) begin
            wbyte(q[k], ack);
            chk(ack, "R9 data ack", ack, 1);
        end
        chk(wr_n - base == 4, "R9 count", wr_n - base, 4);
        for (int k = 0; k < 4; k++)
            chk(wr_log[(base + k) % 256] == q[k], "R9 data", wr_log[(base + k) % 256], q[k]);
        bus_stop();
        wq(4);
        chk(!selected && !sda_oe, "R2 stop idle", selected, 0);

        // Random mix, fixed seed
        void'($urandom(32'h5A17));
        for (int t = 0; t < 30; t++) begin
            bit want, rdm;
            dev_sel = 3'($urandom_range(0, 7));
            rdm = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0:       addr = 8'($urandom);
                1:       addr = {4'b0011, 3'($urandom_range(0, 7)), rdm};
                default: addr = {4'b0011, dev_sel, rdm};
            endcase
            want = exp_ack(addr, dev_sel);
            nb = $urandom_range(1, 3);
            for (int k = 0; k < 4; k++) q[k] = 8'($urandom);
            rd_data = q[0];
            bus_start();
            wbyte(addr, ack);
            chk(ack == want, "R4 match", ack, want);
            if (!want) begin
                oe0 = oe_cycles;
                wbyte(8'($urandom), ack);
                chk(oe_cycles == oe0 && !ack, "R5 silent", oe_cycles - oe0, 0);
            end else begin
                chk(rw_dir == addr[0], "R7 dir", rw_dir, addr[0]);
                if (!addr[0]) begin
                    base = wr_n;
                    for (int k = 0; k < nb; k++) begin
                        wbyte(q[k], ack);
                        chk(ack, "R9 data ack", ack, 1);
                    end
                    chk(wr_n - base == nb, "R9 count", wr_n - base, nb);
                    for (int k = 0; k < nb; k++)
                        chk(wr_log[(base + k) % 256] == q[k], "R9 data", wr_log[(base + k) % 256], q[k]);
                end else begin
                    for (int k = 0; k < nb; k++) begin
                        rbyte(got, k < nb - 1, q[(k + 1) % 4]);
                        chk(got == q[k], "R10 read data", got, q[k]);
                    end
                    oe0 = oe_cycles;
                    wbyte(8'hFF, ack);
                    chk(oe_cycles == oe0, "R11 after nack", oe_cycles - oe0, 0);
                end
            end
            bus_stop();
            wq(4);
            chk(!selected, "R2 stop idle", selected, 0);
        end

        // R8: repeated START in the middle of a write byte
        dev_sel = 3'd5;
        bus_start();
        wbyte({4'b0011, 3'd5, 1'b0}, ack);
        chk(ack, "R8 first addr", ack, 1);
        base = wr_n;
        for (int i = 0; i < 4; i++) bit_cycle(1'b0, s);
        bus_start();
        chk(!selected && wr_n == base, "R8 abort", wr_n - base, 0);
        rd_data = 8'h96;
        wbyte({4'b0011, 3'd5, 1'b1}, ack);
        chk(ack && rw_dir, "R8 restart read", {ack, rw_dir}, 3);
        rbyte(got, 1'b0, 8'h00);
        chk(got == 8'h96, "R10 read after restart", got, 8'h96);
        oe0 = oe_cycles;
        wbyte(8'hFF, ack);
        chk(oe_cycles == oe0, "R11 held off", oe_cycles - oe0, 0);
        bus_stop();

        // R3: SDA rising while SCL high inside a data byte is a STOP
        bus_start();
        wbyte({4'b0011, 3'd5, 1'b0}, ack);
        base = wr_n;
        for (int i = 0; i < 3; i++) bit_cycle(1'b1, s);
        sda_m = 0; wq(Q);
        scl_m = 1; wq(Q);
        sda_m = 1; wq(Q);
        chk(!selected && wr_n == base, "R3 stop mid-byte", selected, 0);
        scl_m = 0; wq(Q);
        oe0 = oe_cycles;
        wbyte(8'h5A, ack);
        wbyte(8'h5A, ack);
        chk(oe_cycles == oe0 && wr_n == base, "R3 ignored after stop", wr_n - base, 0);
        scl_m = 1; wq(Q); bus_stop();

        chk(wide_pulses == 0, "R9 pulse width", wide_pulses, 0);
        chk(hi_changes == 0, "R10 sda stable scl high", hi_changes, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    always @(negedge clk) begin
        if (cyc > WD_MAX) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, WD_MAX);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule